// File: doc/BRIEF.md
# Multi-Sample Sensor Debounce Filter

This block cleans up mechanical chatter on slow sensor lines. Two channels are provided by default: one for a home-position sensor and one for a paper-detect sensor. Each raw line first passes through a two-flop synchronizer. A shared divider then produces a sampling strobe once every 32 system clocks, which is 1.008 MHz from a 32.256 MHz system clock. A channel takes a new level only after enough consecutive samples disagree with its current filtered level.

Two separate thresholds set how many agreeing samples a channel needs. One applies to low-to-high transitions and the other to high-to-low transitions. Each threshold is a 16-bit count of sample periods. The range runs from 2 samples (about 2 µs) up to 65535 samples (about 65 ms). For each channel the block drives the filtered level and a single-cycle pulse on each filtered rising and falling transition. The thresholds are plain input ports. Register decode and interrupt routing belong to the surrounding logic.

Top module: `sensor_debounce_top`

## Requirements
- R1: After synchronous reset every filtered level is 0 and no edge pulse is asserted.
- R2: The sampling strobe fires exactly once every DIV (default 32) system clocks, and filtered levels change only in the cycle after a strobe.
- R3: A filtered level rises from 0 to 1 only after `rise_limit` consecutive samples of the synchronized input read 1. A change to the raw input at cycle t therefore shows at the output no earlier than t+(N-1)*32+3 and no later than t+(N-1)*32+40, where N is the effective threshold.
- R4: The filtered level falls from 1 to 0 after `fall_limit` consecutive samples read 0, with the same timing bounds. The fall threshold is independent of the rise threshold.
- R5: A threshold value of 0 or 1 acts as 2.
- R6: A sample that agrees with the current filtered level restarts the match count. A disturbance lasting fewer than N sample periods therefore leaves the level and the edge pulses untouched.
- R7: `rise_pulse[i]` is high for exactly the one cycle in which `level[i]` goes from 0 to 1. `fall_pulse[i]` is high for exactly the one cycle in which it goes from 1 to 0. No other level change happens.
- R8: Channels are independent. Activity on one raw input never changes the level or the pulses of another channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| raw_in | input | NUM_CH | Asynchronous raw sensor lines, bit 0 home position, bit 1 paper detect |
| rise_limit | input | CNT_W | Samples needed to accept a 0-to-1 transition |
| fall_limit | input | CNT_W | Samples needed to accept a 1-to-0 transition |
| level | output | NUM_CH | Filtered sensor levels |
| rise_pulse | output | NUM_CH | One-cycle flag on a filtered rising transition |
| fall_pulse | output | NUM_CH | One-cycle flag on a filtered falling transition |

## Verification
The assertions assume the thresholds are quasi-static, meaning they do not change while a channel is partway through a match count. They also assume the raw lines need no more than the two-flop synchronizer to settle. The stimulus changes `rise_limit` and `fall_limit` only after every channel has settled. It draws each threshold at random from 0 to 6, so the 0 and 1 aliases get exercised. Each disturbance is drawn either well below the accept window or well above it, so that every check has a single expected outcome despite the unknown phase of the strobe.

// File: rtl/sdf_pkg.sv
package sdf_pkg;

    localparam int SDF_NUM_CH = 2;
    localparam int SDF_DIV    = 32;
    localparam int SDF_CNT_W  = 16;
    localparam int SDF_SYNC   = 2;

    typedef struct packed {
        logic level;
        logic rise;
        logic fall;
    } sdf_chan_out_t;

    // Clamp a requested threshold to the two-sample minimum.
    function automatic logic [SDF_CNT_W-1:0] sdf_eff_limit(input logic [SDF_CNT_W-1:0] req);
        if (req < SDF_CNT_W'(2))
            return SDF_CNT_W'(2);
        return req;
    endfunction

endpackage

// File: rtl/sdf_tick_gen.sv
module sdf_tick_gen #(
    parameter int DIV = sdf_pkg::SDF_DIV
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [DW-1:0] LAST = DW'(DIV - 1);

    logic [DW-1:0] phase;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= '0;
            tick  <= 1'b0;
        end else begin
            tick <= (phase == LAST);
            if (phase == LAST)
                phase <= '0;
            else
                phase <= phase + DW'(1);
        end
    end
endmodule

// File: rtl/sdf_sync.sv
module sdf_sync #(
    parameter int WIDTH  = sdf_pkg::SDF_NUM_CH,
    parameter int STAGES = sdf_pkg::SDF_SYNC
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++)
                chain[s] <= '0;
        end else begin
            chain[0] <= d;
            for (int s = 1; s < STAGES; s++)
                chain[s] <= chain[s-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/sdf_channel.sv
module sdf_channel
    import sdf_pkg::*;
#(
    parameter int CNT_W = SDF_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             sample,
    input  logic [CNT_W-1:0] rise_lim,
    input  logic [CNT_W-1:0] fall_lim,
    output sdf_chan_out_t    out,
    output logic [CNT_W-1:0] run_cnt
);
    logic [CNT_W-1:0] need;
    logic [CNT_W-1:0] next_cnt;
    logic             accept;

    always_comb begin
        need     = out.level ? fall_lim : rise_lim;
        next_cnt = run_cnt + CNT_W'(1);
        accept   = tick && (sample != out.level) && (next_cnt >= need);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out     <= '0;
            run_cnt <= '0;
        end else begin
            out.rise <= 1'b0;
            out.fall <= 1'b0;
            if (tick) begin
                if (sample == out.level) begin
                    run_cnt <= '0;
                end else if (accept) begin
                    run_cnt   <= '0;
                    out.level <= sample;
                    out.rise  <= sample;
                    out.fall  <= ~sample;
                end else begin
                    run_cnt <= next_cnt;
                end
            end
        end
    end
endmodule

// File: rtl/sensor_debounce_top.sv
module sensor_debounce_top
    import sdf_pkg::*;
#(
    parameter int NUM_CH = SDF_NUM_CH,
    parameter int DIV    = SDF_DIV,
    parameter int CNT_W  = SDF_CNT_W,
    parameter int SYNC   = SDF_SYNC
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] raw_in,
    input  logic [CNT_W-1:0]  rise_limit,
    input  logic [CNT_W-1:0]  fall_limit,
    output logic [NUM_CH-1:0] level,
    output logic [NUM_CH-1:0] rise_pulse,
    output logic [NUM_CH-1:0] fall_pulse
);
    logic              tick;
    logic [NUM_CH-1:0] synced;
    logic [CNT_W-1:0]  rise_eff;
    logic [CNT_W-1:0]  fall_eff;
    logic [CNT_W-1:0]  run_cnt [NUM_CH];

    assign rise_eff = sdf_eff_limit(rise_limit);
    assign fall_eff = sdf_eff_limit(fall_limit);

    sdf_tick_gen #(.DIV(DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    sdf_sync #(.WIDTH(NUM_CH), .STAGES(SYNC)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_in),
        .q   (synced)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        sdf_chan_out_t ch_out;

        sdf_channel #(.CNT_W(CNT_W)) u_ch (
            .clk      (clk),
            .rst      (rst),
            .tick     (tick),
            .sample   (synced[i]),
            .rise_lim (rise_eff),
            .fall_lim (fall_eff),
            .out      (ch_out),
            .run_cnt  (run_cnt[i])
        );

        assign level[i]      = ch_out.level;
        assign rise_pulse[i] = ch_out.rise;
        assign fall_pulse[i] = ch_out.fall;
    end
endmodule

// File: rtl/sensor_debounce_checker.sv
module sensor_debounce_checker #(
    parameter int NUM_CH = 2,
    parameter int DIV    = 32,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              tick,
    input logic [CNT_W-1:0]  rise_eff,
    input logic [CNT_W-1:0]  fall_eff,
    input logic [NUM_CH-1:0] level,
    input logic [NUM_CH-1:0] rise_pulse,
    input logic [NUM_CH-1:0] fall_pulse
);
    logic [31:0] gap;
    logic        seen_tick;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap       <= '0;
            seen_tick <= 1'b0;
        end else if (tick) begin
            gap       <= 32'd1;
            seen_tick <= 1'b1;
        end else begin
            gap <= gap + 32'd1;
        end
    end

    // R2: strobe spacing equals DIV once a first strobe was seen
    a_r2_tick_spacing: assert property (@(posedge clk) disable iff (rst)
        (tick && seen_tick) |-> (gap == 32'(DIV)));

    // R2: no strobe gap longer than DIV
    a_r2_tick_no_stall: assert property (@(posedge clk) disable iff (rst)
        gap <= 32'(DIV));

    // R5: effective thresholds never below two
    a_r5_min_limit: assert property (@(posedge clk) disable iff (rst)
        (rise_eff >= CNT_W'(2)) && (fall_eff >= CNT_W'(2)));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        // R7: rise pulse marks the 0-to-1 change
        a_r7_rise_marks_edge: assert property (@(posedge clk) disable iff (rst)
            rise_pulse[i] |-> (level[i] && !$past(level[i])));
        // R7: fall pulse marks the 1-to-0 change
        a_r7_fall_marks_edge: assert property (@(posedge clk) disable iff (rst)
            fall_pulse[i] |-> (!level[i] && $past(level[i])));
        // R7: every level change is flagged
        a_r7_change_flagged: assert property (@(posedge clk) disable iff (rst)
            (level[i] != $past(level[i])) |-> (rise_pulse[i] || fall_pulse[i]));
        // R7: both flags never together
        a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
            !(rise_pulse[i] && fall_pulse[i]));
        // R2: level moves only right after a strobe
        a_r2_change_on_tick: assert property (@(posedge clk) disable iff (rst)
            (level[i] != $past(level[i])) |-> $past(tick));
    end

    // R1: outputs quiet right after reset
    a_r1_reset_state: assert property (@(posedge clk)
        $past(rst) |-> (level == '0 && rise_pulse == '0 && fall_pulse == '0));
endmodule

bind sensor_debounce_top sensor_debounce_checker #(
    .NUM_CH (NUM_CH),
    .DIV    (DIV),
    .CNT_W  (CNT_W)
) u_checker (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .rise_eff   (rise_eff),
    .fall_eff   (fall_eff),
    .level      (level),
    .rise_pulse (rise_pulse),
    .fall_pulse (fall_pulse)
);

// File: tb/sensor_debounce_top_bench.sv
`timescale 1ns/1ps
module sensor_debounce_top_bench;
    localparam int NCH = 2;
    localparam int DIV = 32;
    localparam int CW  = 16;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [NCH-1:0] raw_in = '0;
    logic [CW-1:0]  rise_limit = 16'd3;
    logic [CW-1:0]  fall_limit = 16'd3;
    logic [NCH-1:0] level, rise_pulse, fall_pulse;

    int checks = 0;
    int failures = 0;
    int rise_cnt [NCH];
    int fall_cnt [NCH];
    bit done = 0;

    always #10 clk = ~clk;

    sensor_debounce_top u_sensor_debounce_top (
        .clk        (clk),
        .rst        (rst),
        .raw_in     (raw_in),
        .rise_limit (rise_limit),
        .fall_limit (fall_limit),
        .level      (level),
        .rise_pulse (rise_pulse),
        .fall_pulse (fall_pulse)
    );

    always @(negedge clk) begin
        for (int i = 0; i < NCH; i++) begin
            if (rise_pulse[i]) rise_cnt[i]++;
            if (fall_pulse[i]) fall_cnt[i]++;
        end
    end

    function automatic int eff(input logic [CW-1:0] t);
        return (t < 2) ? 2 : int'(t);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Move channel ch to value v and check timing bounds and pulses.
    task automatic long_change(input int ch, input bit v, input string req);
        int n, r0, f0, oc, lv_other;
        n  = v ? eff(rise_limit) : eff(fall_limit);
        r0 = rise_cnt[ch];
        f0 = fall_cnt[ch];
        oc = 1 - ch;
        lv_other = int'(level[oc]);
        raw_in[ch] = v;
        wait_cyc((n - 1) * DIV);
        check({req, " early hold"}, int'(level[ch]), int'(!v));
        wait_cyc(40);
        check({req, " accepted"}, int'(level[ch]), int'(v));
        check("R7 rise count", rise_cnt[ch] - r0, v ? 1 : 0);
        check("R7 fall count", fall_cnt[ch] - f0, v ? 0 : 1);
        check("R8 other channel", int'(level[oc]), lv_other);
    endtask

    // Short disturbance that must be filtered out.
    task automatic glitch(input int ch, input string req);
        int n, len, r0, f0;
        bit cur;
        cur = level[ch];
        n   = cur ? eff(fall_limit) : eff(rise_limit);
        len = 1 + int'($urandom % ((n - 1) * DIV - 8));
        r0 = rise_cnt[ch];
        f0 = fall_cnt[ch];
        raw_in[ch] = !cur;
        wait_cyc(len);
        raw_in[ch] = cur;
        wait_cyc(n * DIV + 40);
        check({req, " glitch level"}, int'(level[ch]), int'(cur));
        check({req, " glitch pulses"}, (rise_cnt[ch] - r0) + (fall_cnt[ch] - f0), 0);
    endtask

    initial begin
        void'($urandom(32'd7351));
        wait_cyc(4);
        check("R1 level after reset", int'(level), 0);
        check("R1 pulses after reset", int'(rise_pulse | fall_pulse), 0);
        @(negedge clk) rst = 1'b0;
        wait_cyc(4);

        // R3 / R4 with different thresholds
        rise_limit = 16'd4;
        fall_limit = 16'd2;
        long_change(0, 1'b1, "R3");
        long_change(0, 1'b0, "R4");
        // R5: 0 and 1 alias to 2
        rise_limit = 16'd0;
        fall_limit = 16'd1;
        long_change(1, 1'b1, "R5 rise");
        long_change(1, 1'b0, "R5 fall");
        // R6 directed
        rise_limit = 16'd5;
        fall_limit = 16'd5;
        glitch(0, "R6");
        long_change(0, 1'b1, "R3");
        glitch(0, "R6");

        // Constrained random mix
        for (int it = 0; it < 24; it++) begin
            int ch;
            ch = int'($urandom % NCH);
            rise_limit = CW'($urandom % 7);
            fall_limit = CW'($urandom % 7);
            if ($urandom % 2)
                glitch(ch, "R6");
            else
                long_change(ch, !level[ch], level[ch] ? "R4" : "R3");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule